// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block keeps a small set of one-bit tokens that two independent agents, a left port and a right port, use to claim shared resources. Each port has its own select lines, a write strobe, a read enable, a flag address and a byte-wide data path. A port claims a token by writing a 0 to it. It gives the token up by writing a 1. It learns whether it holds the token by reading the flag.

Each port keeps one request bit per flag. Ownership is granted only when the other port does not already hold that flag. When both ports reach for a free flag in the same cycle, the left port gets it. A refused request stays pending and turns into ownership by itself once the holder lets go. Everything runs on one clock. The rising edge of each port's write strobe is found by a registered edge detector. The pad-level tri-state is modelled as a data vector plus an enable.

Top module: `sem_unit`

## Requirements
- R1: After reset every request bit is clear and no port owns any flag, so a read of any flag from either port returns 8'hFF.
- R2: A port performs a semaphore access only while its semaphore select (active low) is 0 and its memory select (active low) is 1. With semaphore select at 1, writes change nothing and the output enable stays low.
- R3: A write takes effect on the first clock edge at which the port's write strobe (active low) is sampled high after being low. Only data bit 0 is used, at the 3-bit address sampled on that edge: 0 sets that port's request for the flag and 1 clears it.
- R4: During a valid read (semaphore access, write strobe high, read enable at 0), the output enable is 1 and the data is 8'h00 when the reading port owns the addressed flag and 8'hFF otherwise.
- R5: An access with memory select and semaphore select both at 0 is illegal. A strobe edge during it changes no request, and the output enable stays low.
- R6: The two ports never own the same flag at once. A request for a flag the other port owns is refused, and reads from the requester keep returning 8'hFF.
- R7: When both ports hold a new request for the same free flag in the same cycle, the left port is granted.
- R8: A pending refused request is granted without any new write. Ownership appears one clock after the owner's ownership clears, which is two clocks after the owner's release edge.
- R9: Whenever the output enable is low, the data output is 8'h00.
- R10: The two ports operate independently. Simultaneous requests to different flags are both granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_mem_sel_ni | input | 1 | Left memory select, active low (1 is needed for a semaphore access) |
| l_sem_sel_ni | input | 1 | Left semaphore select, active low |
| l_wr_ni | input | 1 | Left write strobe, active low; the rising edge commits |
| l_rd_ni | input | 1 | Left read enable, active low |
| l_addr_i | input | 3 | Left flag address |
| l_data_i | input | 8 | Left write data (bit 0 used) |
| l_data_o | output | 8 | Left read data |
| l_data_oe_o | output | 1 | Left data drive enable |
| r_mem_sel_ni | input | 1 | Right memory select, active low |
| r_sem_sel_ni | input | 1 | Right semaphore select, active low |
| r_wr_ni | input | 1 | Right write strobe, active low |
| r_rd_ni | input | 1 | Right read enable, active low |
| r_addr_i | input | 3 | Right flag address |
| r_data_i | input | 8 | Right write data (bit 0 used) |
| r_data_o | output | 8 | Right read data |
| r_data_oe_o | output | 1 | Right data drive enable |

## Verification
The bench aims at the contention corners. A design that let both ports hold the same flag would show 8'h00 to both readers. A tie resolved toward the right port would flip the two read values. A design that dropped refused requests would leave the waiting port reading 8'hFF forever after the release. Illegal and deselected accesses are probed by writing a release through them and then reading back ownership over a legal access. This catches a design that decodes the selects loosely. Writes with upper data bits set expose a design that looks past bit 0.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int unsigned NUM_FLAGS = 8;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = $clog2(NUM_FLAGS);

  typedef enum logic [1:0] {
    ACC_IDLE    = 2'd0,
    ACC_SEM     = 2'd1,
    ACC_ILLEGAL = 2'd2
  } acc_e;
endpackage

// File: rtl/sem_port.sv
module sem_port
  import sem_pkg::*;
#(
  parameter int unsigned N_FLAGS = NUM_FLAGS,
  parameter int unsigned DW      = DATA_W,
  localparam int unsigned AW     = $clog2(N_FLAGS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mem_sel_ni,
  input  logic               sem_sel_ni,
  input  logic               wr_ni,
  input  logic               rd_ni,
  input  logic [AW-1:0]      addr_i,
  input  logic [DW-1:0]      data_i,
  input  logic [N_FLAGS-1:0] own_i,
  output logic [N_FLAGS-1:0] set_o,
  output logic [N_FLAGS-1:0] clr_o,
  output logic [DW-1:0]      data_o,
  output logic               data_oe_o
);
  acc_e acc;
  logic wr_q, wr_rise, stb;

  always_comb begin
    if (!sem_sel_ni && !mem_sel_ni)     acc = ACC_ILLEGAL;
    else if (!sem_sel_ni && mem_sel_ni) acc = ACC_SEM;
    else                                acc = ACC_IDLE;
  end

  // registered edge detector on the write strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_ni;
  end

  assign wr_rise = wr_ni & ~wr_q;
  assign stb     = wr_rise && (acc == ACC_SEM);

  always_comb begin
    set_o = '0;
    clr_o = '0;
    if (stb) begin
      if (data_i[0]) clr_o = N_FLAGS'(1) << addr_i;
      else           set_o = N_FLAGS'(1) << addr_i;
    end
  end

  assign data_oe_o = (acc == ACC_SEM) && wr_ni && !rd_ni;
  assign data_o    = !data_oe_o ? '0 : (own_i[addr_i] ? '0 : '1);
endmodule

// File: rtl/sem_flag.sv
module sem_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_l_i,
  input  logic clr_l_i,
  input  logic set_r_i,
  input  logic clr_r_i,
  output logic req_l_o,
  output logic req_r_o,
  output logic own_l_o,
  output logic own_r_o
);
  logic own_l_d, own_r_d;

  // left keeps or takes unless right holds; right takes only if left neither holds nor asks
  assign own_l_d = req_l_o & (own_l_o | ~own_r_o);
  assign own_r_d = req_r_o & (own_r_o | (~own_l_o & ~req_l_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_l_o <= 1'b0;
      req_r_o <= 1'b0;
      own_l_o <= 1'b0;
      own_r_o <= 1'b0;
    end else begin
      if (set_l_i)      req_l_o <= 1'b1;
      else if (clr_l_i) req_l_o <= 1'b0;
      if (set_r_i)      req_r_o <= 1'b1;
      else if (clr_r_i) req_r_o <= 1'b0;
      own_l_o <= own_l_d;
      own_r_o <= own_r_d;
    end
  end
endmodule

// File: rtl/sem_unit.sv
module sem_unit
  import sem_pkg::*;
#(
  parameter int unsigned N_FLAGS = NUM_FLAGS,
  parameter int unsigned DW      = DATA_W,
  localparam int unsigned AW     = $clog2(N_FLAGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_mem_sel_ni,
  input  logic          l_sem_sel_ni,
  input  logic          l_wr_ni,
  input  logic          l_rd_ni,
  input  logic [AW-1:0] l_addr_i,
  input  logic [DW-1:0] l_data_i,
  output logic [DW-1:0] l_data_o,
  output logic          l_data_oe_o,
  input  logic          r_mem_sel_ni,
  input  logic          r_sem_sel_ni,
  input  logic          r_wr_ni,
  input  logic          r_rd_ni,
  input  logic [AW-1:0] r_addr_i,
  input  logic [DW-1:0] r_data_i,
  output logic [DW-1:0] r_data_o,
  output logic          r_data_oe_o
);
  logic [N_FLAGS-1:0] set_l, clr_l, set_r, clr_r;
  logic [N_FLAGS-1:0] req_l, req_r, own_l, own_r;

  sem_port #(.N_FLAGS(N_FLAGS), .DW(DW)) u_port_l (
    .clk_i, .rst_ni,
    .mem_sel_ni(l_mem_sel_ni), .sem_sel_ni(l_sem_sel_ni),
    .wr_ni(l_wr_ni), .rd_ni(l_rd_ni), .addr_i(l_addr_i), .data_i(l_data_i),
    .own_i(own_l), .set_o(set_l), .clr_o(clr_l),
    .data_o(l_data_o), .data_oe_o(l_data_oe_o)
  );

  sem_port #(.N_FLAGS(N_FLAGS), .DW(DW)) u_port_r (
    .clk_i, .rst_ni,
    .mem_sel_ni(r_mem_sel_ni), .sem_sel_ni(r_sem_sel_ni),
    .wr_ni(r_wr_ni), .rd_ni(r_rd_ni), .addr_i(r_addr_i), .data_i(r_data_i),
    .own_i(own_r), .set_o(set_r), .clr_o(clr_r),
    .data_o(r_data_o), .data_oe_o(r_data_oe_o)
  );

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    sem_flag u_flag (
      .clk_i, .rst_ni,
      .set_l_i(set_l[g]), .clr_l_i(clr_l[g]),
      .set_r_i(set_r[g]), .clr_r_i(clr_r[g]),
      .req_l_o(req_l[g]), .req_r_o(req_r[g]),
      .own_l_o(own_l[g]), .own_r_o(own_r[g])
    );
  end
endmodule

// File: rtl/sem_unit_chk.sv
module sem_unit_chk #(
  parameter int unsigned N_FLAGS = 8,
  parameter int unsigned DW      = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               l_mem_sel_ni,
  input logic               l_sem_sel_ni,
  input logic               r_mem_sel_ni,
  input logic               r_sem_sel_ni,
  input logic [DW-1:0]      l_data_o,
  input logic               l_data_oe_o,
  input logic [DW-1:0]      r_data_o,
  input logic               r_data_oe_o,
  input logic [N_FLAGS-1:0] req_l,
  input logic [N_FLAGS-1:0] req_r,
  input logic [N_FLAGS-1:0] own_l,
  input logic [N_FLAGS-1:0] own_r
);
  p_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0);

  p_grant_needs_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((own_l & ~$past(own_l) & ~$past(req_l)) == '0) &&
    ((own_r & ~$past(own_r) & ~$past(req_r)) == '0));

  p_tie_left_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(req_l & req_r & ~own_l & ~own_r) & own_r) == '0);

  p_illegal_l_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_mem_sel_ni && !l_sem_sel_ni) |=> (req_l == $past(req_l)));

  p_illegal_r_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!r_mem_sel_ni && !r_sem_sel_ni) |=> (req_r == $past(req_r)));

  p_idle_l_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_sem_sel_ni |=> (req_l == $past(req_l)));

  p_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!l_data_oe_o -> l_data_o == '0) && (!r_data_oe_o -> r_data_o == '0));

  p_read_val_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_data_oe_o -> (l_data_o == '0 || l_data_o == '1)) &&
    (r_data_oe_o -> (r_data_o == '0 || r_data_o == '1)));
endmodule

bind sem_unit sem_unit_chk #(.N_FLAGS(N_FLAGS), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_mem_sel_ni(l_mem_sel_ni), .l_sem_sel_ni(l_sem_sel_ni),
  .r_mem_sel_ni(r_mem_sel_ni), .r_sem_sel_ni(r_sem_sel_ni),
  .l_data_o(l_data_o), .l_data_oe_o(l_data_oe_o),
  .r_data_o(r_data_o), .r_data_oe_o(r_data_oe_o),
  .req_l(req_l), .req_r(req_r), .own_l(own_l), .own_r(own_r)
);

// File: tb/tb_sem_unit.sv
module tb_sem_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       l_ms = 1'b1, l_ss = 1'b1, l_wr = 1'b1, l_rd = 1'b1;
  logic [2:0] l_a = '0;
  logic [7:0] l_d = '0;
  logic       r_ms = 1'b1, r_ss = 1'b1, r_wr = 1'b1, r_rd = 1'b1;
  logic [2:0] r_a = '0;
  logic [7:0] r_d = '0;
  logic [7:0] l_q, r_q;
  logic       l_oe, r_oe;

  int tests = 0;
  int fails = 0;

  sem_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_mem_sel_ni(l_ms), .l_sem_sel_ni(l_ss), .l_wr_ni(l_wr), .l_rd_ni(l_rd),
    .l_addr_i(l_a), .l_data_i(l_d), .l_data_o(l_q), .l_data_oe_o(l_oe),
    .r_mem_sel_ni(r_ms), .r_sem_sel_ni(r_ss), .r_wr_ni(r_wr), .r_rd_ni(r_rd),
    .r_addr_i(r_a), .r_data_i(r_d), .r_data_o(r_q), .r_data_oe_o(r_oe)
  );

  // behavioural reference
  bit m_req_l[8], m_req_r[8], m_own_l[8], m_own_r[8];
  bit m_wq_l = 1'b1, m_wq_r = 1'b1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_req_l[i]) begin
        m_req_l[i] = 0; m_req_r[i] = 0; m_own_l[i] = 0; m_own_r[i] = 0;
      end
      m_wq_l = 1; m_wq_r = 1;
    end else begin
      bit nl[8], nr[8];
      foreach (nl[i]) begin
        if (!m_req_l[i])      nl[i] = 0;
        else if (m_own_l[i])  nl[i] = 1;
        else                  nl[i] = !m_own_r[i];
        if (!m_req_r[i])      nr[i] = 0;
        else if (m_own_r[i])  nr[i] = 1;
        else                  nr[i] = !m_own_l[i] && !m_req_l[i];
      end
      if (l_wr && !m_wq_l && !l_ss && l_ms) m_req_l[l_a] = !l_d[0];
      if (r_wr && !m_wq_r && !r_ss && r_ms) m_req_r[r_a] = !r_d[0];
      m_wq_l = l_wr; m_wq_r = r_wr;
      m_own_l = nl; m_own_r = nr;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      logic       el, er;
      logic [7:0] dl, dr;
      el = !l_ss && l_ms && l_wr && !l_rd;
      er = !r_ss && r_ms && r_wr && !r_rd;
      dl = !el ? 8'h00 : (m_own_l[l_a] ? 8'h00 : 8'hFF);
      dr = !er ? 8'h00 : (m_own_r[r_a] ? 8'h00 : 8'hFF);
      chk({l_oe, l_q} == {el, dl}, "R4/R9 left model", {l_oe, l_q}, {el, dl});
      chk({r_oe, r_q} == {er, dr}, "R4/R9 right model", {r_oe, r_q}, {er, dr});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one strobe pulse on the selected ports; selects held through the edge
  task automatic wr(input bit dl, input logic [2:0] al, input logic [7:0] vl,
                    input bit dr, input logic [2:0] ar, input logic [7:0] vr);
    @(negedge clk);
    if (dl) begin l_ss = 0; l_ms = 1; l_a = al; l_d = vl; l_wr = 0; end
    if (dr) begin r_ss = 0; r_ms = 1; r_a = ar; r_d = vr; r_wr = 0; end
    @(negedge clk);
    if (dl) l_wr = 1;
    if (dr) r_wr = 1;
    @(negedge clk);
    l_ss = 1; r_ss = 1;
    idle(3);
  endtask

  task automatic rd(input bit left, input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    if (left) begin l_ss = 0; l_ms = 1; l_a = a; l_rd = 0; end
    else      begin r_ss = 0; r_ms = 1; r_a = a; r_rd = 0; end
    #1;
    if (left) chk(l_oe && l_q == exp, tag, {l_oe, l_q}, {1'b1, exp});
    else      chk(r_oe && r_q == exp, tag, {r_oe, r_q}, {1'b1, exp});
    @(negedge clk);
    l_ss = 1; l_rd = 1; r_ss = 1; r_rd = 1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    tests++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    #1;
    chk(!l_oe && !r_oe && l_q == 0 && r_q == 0, "R1 outputs idle after reset", {l_oe, l_q}, 9'h0);
    for (int i = 0; i < 8; i++) rd(1, 3'(i), 8'hFF, "R1 left free after reset");
    for (int i = 0; i < 8; i++) rd(0, 3'(i), 8'hFF, "R1 right free after reset");

    // R3: request with upper bits set, only bit 0 counts
    wr(1, 3, 8'hFE, 0, 0, 0);
    rd(1, 3, 8'h00, "R3 left owns flag 3");
    rd(0, 3, 8'hFF, "R6 right sees flag 3 taken");

    // R6: right refused
    wr(0, 0, 0, 1, 3, 8'h00);
    rd(0, 3, 8'hFF, "R6 right refused");
    rd(1, 3, 8'h00, "R6 left keeps flag 3");

    // R8: release with bit0=1, upper bits 0; right granted while pending
    wr(1, 3, 8'h01, 0, 0, 0);
    rd(0, 3, 8'h00, "R8 pending right granted");
    rd(1, 3, 8'hFF, "R8 left released");
    wr(0, 0, 0, 1, 3, 8'h01);
    rd(0, 3, 8'hFF, "R3 right released");

    // R7: tie on flag 5
    wr(1, 5, 8'h00, 1, 5, 8'h00);
    rd(1, 5, 8'h00, "R7 left wins tie");
    rd(0, 5, 8'hFF, "R7 right loses tie");

    // R5: illegal release attempt by left
    @(negedge clk);
    l_ms = 0; l_ss = 0; l_a = 5; l_d = 8'h01; l_wr = 0; l_rd = 1;
    @(negedge clk);
    l_wr = 1;
    #1;
    chk(!l_oe && l_q == 0, "R5 illegal no drive (wr high)", {l_oe, l_q}, 9'h0);
    @(negedge clk);
    l_rd = 0;
    #1;
    chk(!l_oe && l_q == 0, "R5 illegal read no drive", {l_oe, l_q}, 9'h0);
    @(negedge clk);
    l_ms = 1; l_ss = 1; l_rd = 1;
    idle(3);
    rd(1, 5, 8'h00, "R5 illegal release ignored");

    // R2: deselected release attempt
    @(negedge clk);
    l_ms = 1; l_ss = 1; l_a = 5; l_d = 8'h01; l_wr = 0; l_rd = 0;
    #1;
    chk(!l_oe && l_q == 0, "R2 deselected no drive", {l_oe, l_q}, 9'h0);
    @(negedge clk);
    l_wr = 1;
    @(negedge clk);
    l_rd = 1;
    idle(3);
    rd(1, 5, 8'h00, "R2 deselected release ignored");

    // release flag 5 from left, right pending takes it
    wr(1, 5, 8'h01, 0, 0, 0);
    rd(0, 5, 8'h00, "R8 right takes flag 5");
    wr(0, 0, 0, 1, 5, 8'h01);

    // R10: independent flags at once
    wr(1, 1, 8'h00, 1, 2, 8'h00);
    rd(1, 1, 8'h00, "R10 left owns 1");
    rd(0, 2, 8'h00, "R10 right owns 2");
    rd(1, 2, 8'hFF, "R10 left sees 2 taken");
    rd(0, 1, 8'hFF, "R10 right sees 1 taken");
    wr(1, 1, 8'h01, 1, 2, 8'h01);
    for (int i = 0; i < 8; i++) rd(1, 3'(i), 8'hFF, "R3 all free at end");

    idle(2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule